// File: doc/BRIEF.md
# Lane Swizzle Crossbar

This block rearranges the data words of a 32-lane group. Each cycle a caller may present one full vector of lane words together with a 16-bit pattern word. The pattern decoder turns the pattern into a single rule. A per-lane source calculator then works out, for every destination lane, which source lane it reads. A crossbar multiplexer moves that lane's word into an output register. The result appears one clock later with a valid strobe.

Five rearrangements are supported: a permutation inside each quad of four lanes, a per-bit transform of the 5-bit lane id, a broadcast of one lane to its whole group, an exchange of neighbouring groups, and a reversal inside each group. Except for the quad permutation, each rule reduces to the expression `((id AND a) OR o) XOR x`. A per-lane enable input stops individual destination lanes from being written. The lane count, the word width and the shape of the multiplexer are parameters.

Top module: `lane_swizzle_xbar`

## Requirements
- R1: When pattern bit 15 is 1 (quad permute), destination lane l reads the lane of its own quad whose position is pattern[2p+1:2p], where p = l mod 4.
- R2: When bit 15 is 0, bits 11:10 are 00 and bits 14:12 are 000 (bitmask), source id bit k is set by the 2-bit code at pattern[2k+1:2k]. Code 00 gives 0, 01 gives 1, 10 keeps the bit and 11 inverts it. The all-zero pattern therefore sends lane 0 to every lane.
- R3: With bits 14:12 = 001 (broadcast) and size code k = pattern[2:0] in 1..5, each group of 2^k lanes receives the lane at position pattern[8:4] within that group. Index bits at or above position k are ignored.
- R4: With bits 14:12 = 010 (swap) and k in 0..4, each lane reads the lane whose id differs only in bit k. This exchanges neighbouring groups of 2^k lanes.
- R5: With bits 14:12 = 011 (reverse) and k in 1..5, lane order is reversed inside each group of 2^k lanes.
- R6: Every lane reads itself (identity) in these cases: a non-quad pattern with bits 11:10 nonzero, mode codes 100 to 111, a broadcast or reverse size code of 0 or above 5, or a swap size code above 4.
- R7: valid_o is 1 exactly in the cycle after a cycle with valid_i = 1. The rearranged data is written on that same clock edge.
- R8: A lane whose lane_en_i bit is 0, or any lane in a cycle with valid_i = 0, keeps its previous output word.
- R9: While rst_n is 0 at a clock edge, valid_o and every output word become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Input vector and pattern are valid this cycle |
| pattern_i | input | 16 | Rearrangement pattern word |
| lane_en_i | input | LANES | Per-destination-lane write enable |
| data_i | input | LANES*DW | Input lane words, lane l at bits [l*DW +: DW] |
| valid_o | output | 1 | Output vector updated on the last edge |
| data_o | output | LANES*DW | Registered output lane words |

## Verification
The input words carry their own lane number, so a misrouted lane can be told apart from a stale one. The quad tests use a non-trivial selector set and the all-same selector set. These separate per-position decoding from plain copying. Bitmask tests cover the all-zero pattern and a mix of the four codes. Broadcast, swap and reverse each run at their smallest and largest group sizes. This exposes off-by-one errors in the mask derived from the size code, and broadcast with stray high index bits checks that those bits are masked off. Out-of-range size codes, reserved bits and unused mode codes must all give identity routing. Enable masks and idle cycles confirm that unwritten lanes hold their words.

// File: rtl/swz_pkg.sv
package swz_pkg;
   localparam int PAT_W     = 16;
   localparam int QUAD_BIT  = 15;
   localparam int MODE_LSB  = 12;
   localparam int RSV_LSB   = 10;
   localparam int IDX_LSB   = 4;
   localparam int SIZE_LSB  = 0;
   localparam int SIZE_W    = 3;
   localparam int MAX_ID_W  = 5;

   typedef enum logic [2:0] {
      SWZ_BITMASK = 3'd0,
      SWZ_BCAST   = 3'd1,
      SWZ_SWAP    = 3'd2,
      SWZ_REVERSE = 3'd3
   } swz_mode_e;
endpackage

// File: rtl/swz_pattern_dec.sv
module swz_pattern_dec
   import swz_pkg::*;
#(
   parameter int LW = 5
) (
   input  logic [PAT_W-1:0] pat_i,
   output logic             quad_o,
   output logic [7:0]       qsel_o,
   output logic [LW-1:0]    and_o,
   output logic [LW-1:0]    or_o,
   output logic [LW-1:0]    xor_o
);
   logic [SIZE_W-1:0] size_k;
   logic [LW-1:0]     low_m;
   logic [LW-1:0]     one_m;
   logic              bad_size_grp;
   logic              bad_size_swp;

   assign quad_o = pat_i[QUAD_BIT];
   assign qsel_o = pat_i[7:0];
   assign size_k = pat_i[SIZE_LSB +: SIZE_W];

   // group-size masks derived from the size code
   always_comb begin
      low_m = '0;
      one_m = '0;
      for (int b = 0; b < LW; b++) begin
         if (b < int'(size_k))  low_m[b] = 1'b1;
         if (b == int'(size_k)) one_m[b] = 1'b1;
      end
   end

   assign bad_size_grp = (size_k == '0) || (int'(size_k) > LW);
   assign bad_size_swp = (int'(size_k) >= LW);

   always_comb begin
      and_o = '1;
      or_o  = '0;
      xor_o = '0;
      if (!quad_o && (pat_i[RSV_LSB +: 2] == 2'b00)) begin
         case (pat_i[MODE_LSB +: 3])
            SWZ_BITMASK: begin
               for (int b = 0; b < LW; b++) begin
                  case (pat_i[2*b +: 2])
                     2'b00: and_o[b] = 1'b0;
                     2'b01: begin
                        and_o[b] = 1'b0;
                        or_o[b]  = 1'b1;
                     end
                     2'b10: and_o[b] = 1'b1;
                     default: xor_o[b] = 1'b1;
                  endcase
               end
            end
            SWZ_BCAST: begin
               if (!bad_size_grp) begin
                  and_o = ~low_m;
                  or_o  = pat_i[IDX_LSB +: LW] & low_m;
               end
            end
            SWZ_SWAP: begin
               if (!bad_size_swp) xor_o = one_m;
            end
            SWZ_REVERSE: begin
               if (!bad_size_grp) xor_o = low_m;
            end
            default: begin
               and_o = '1;
            end
         endcase
      end
   end
endmodule

// File: rtl/swz_src_lane.sv
module swz_src_lane #(
   parameter int LW      = 5,
   parameter int LANE_ID = 0
) (
   input  logic          quad_i,
   input  logic [7:0]    qsel_i,
   input  logic [LW-1:0] and_i,
   input  logic [LW-1:0] or_i,
   input  logic [LW-1:0] xor_i,
   output logic [LW-1:0] src_o
);
   localparam logic [LW-1:0] ID  = LW'(LANE_ID);
   localparam int            POS = LANE_ID % 4;

   logic [LW-1:0] quad_src;
   logic [LW-1:0] mask_src;

   assign quad_src = {ID[LW-1:2], qsel_i[2*POS +: 2]};
   assign mask_src = ((ID & and_i) | or_i) ^ xor_i;
   assign src_o    = quad_i ? quad_src : mask_src;
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux #(
   parameter int LANES    = 32,
   parameter int DW       = 32,
   parameter int MUX_TREE = 1,
   localparam int LW      = $clog2(LANES)
) (
   input  logic [LANES*DW-1:0] data_i,
   input  logic [LW-1:0]       sel_i,
   output logic [DW-1:0]       data_o
);
   if (MUX_TREE == 0) begin : g_flat
      assign data_o = data_i[int'(sel_i)*DW +: DW];
   end else begin : g_tree
      for (genvar s = 0; s <= LW; s++) begin : stg
         localparam int N = LANES >> s;
         logic [DW-1:0] v [N];
         if (s == 0) begin : g_leaf
            for (genvar j = 0; j < N; j++) begin : g_in
               assign v[j] = data_i[j*DW +: DW];
            end
         end else begin : g_node
            for (genvar j = 0; j < N; j++) begin : g_sel
               assign v[j] = sel_i[s-1] ? stg[s-1].v[2*j+1] : stg[s-1].v[2*j];
            end
         end
      end
      assign data_o = stg[LW].v[0];
   end
endmodule

// File: rtl/lane_swizzle_xbar.sv
module lane_swizzle_xbar
   import swz_pkg::*;
#(
   parameter int LANES    = 32,
   parameter int DW       = 32,
   parameter int MUX_TREE = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid_i,
   input  logic [PAT_W-1:0]    pattern_i,
   input  logic [LANES-1:0]    lane_en_i,
   input  logic [LANES*DW-1:0] data_i,
   output logic                valid_o,
   output logic [LANES*DW-1:0] data_o
);
   localparam int LW = $clog2(LANES);

   if ((LANES & (LANES - 1)) != 0 || LANES < 8 || LW > MAX_ID_W) begin : g_bad_lanes
      $error("lane_swizzle_xbar: LANES must be a power of two from 8 to 32");
   end
   if (DW < 1) begin : g_bad_dw
      $error("lane_swizzle_xbar: DW must be positive");
   end
   if (MUX_TREE < 0 || MUX_TREE > 1) begin : g_bad_mux
      $error("lane_swizzle_xbar: MUX_TREE must be 0 or 1");
   end

   logic          quad;
   logic [7:0]    qsel;
   logic [LW-1:0] and_m;
   logic [LW-1:0] or_m;
   logic [LW-1:0] xor_m;

   swz_pattern_dec #(.LW(LW)) u_dec (
      .pat_i  (pattern_i),
      .quad_o (quad),
      .qsel_o (qsel),
      .and_o  (and_m),
      .or_o   (or_m),
      .xor_o  (xor_m)
   );

   logic [LANES*DW-1:0] routed;
   logic [LANES*DW-1:0] data_q;
   logic                valid_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0] src;

      swz_src_lane #(.LW(LW), .LANE_ID(l)) u_src (
         .quad_i (quad),
         .qsel_i (qsel),
         .and_i  (and_m),
         .or_i   (or_m),
         .xor_i  (xor_m),
         .src_o  (src)
      );

      swz_lane_mux #(.LANES(LANES), .DW(DW), .MUX_TREE(MUX_TREE)) u_mux (
         .data_i (data_i),
         .sel_i  (src),
         .data_o (routed[l*DW +: DW])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= valid_i;
         for (int l = 0; l < LANES; l++) begin
            if (valid_i && lane_en_i[l]) data_q[l*DW +: DW] <= routed[l*DW +: DW];
         end
      end
   end

   assign valid_o = valid_q;
   assign data_o  = data_q;
endmodule

// File: rtl/swz_xbar_chk.sv
module swz_xbar_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          valid_i,
   input logic [15:0]   pattern_i,
   input logic          en0_i,
   input logic [4*DW-1:0] din_lo_i,
   input logic          valid_o,
   input logic [DW-1:0] dout0_i
);
   logic [DW-1:0] quad_exp0;
   assign quad_exp0 = din_lo_i[int'(pattern_i[1:0])*DW +: DW];

   // R7: output strobe follows the input strobe by one cycle
   a_r7_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o);
   a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !valid_o);

   // R8: lane 0 holds when not written
   a_r8_hold_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i || !en0_i) |=> $stable(dout0_i));

   // R1: lane 0 under quad permute reads the lane named by its selector
   a_r1_quad_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && en0_i && pattern_i[15]) |=> (dout0_i == $past(quad_exp0)));

   // R4: swap of single lanes gives lane 0 the word of lane 1
   a_r4_swap_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && en0_i && pattern_i == 16'h2000) |=> (dout0_i == $past(din_lo_i[2*DW-1:DW])));
endmodule

bind lane_swizzle_xbar swz_xbar_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_i   (valid_i),
   .pattern_i (pattern_i),
   .en0_i     (lane_en_i[0]),
   .din_lo_i  (data_i[4*DW-1:0]),
   .valid_o   (valid_o),
   .dout0_i   (data_o[DW-1:0])
);

// File: tb/lane_swizzle_xbar_tb.sv
module lane_swizzle_xbar_tb;
   localparam int CLK_NS = 10;
   localparam int LANES  = 32;
   localparam int DW     = 32;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                valid_i;
   logic [15:0]         pattern_i;
   logic [LANES-1:0]    lane_en_i;
   logic [LANES*DW-1:0] data_i;
   logic                valid_o;
   logic [LANES*DW-1:0] data_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [DW-1:0] exp_q [LANES];
   logic [DW-1:0] src_w [LANES];

   always #(CLK_NS/2) clk = ~clk;

   lane_swizzle_xbar #(.LANES(LANES), .DW(DW), .MUX_TREE(1)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (valid_i),
      .pattern_i (pattern_i),
      .lane_en_i (lane_en_i),
      .data_i    (data_i),
      .valid_o   (valid_o),
      .data_o    (data_o)
   );

   // source lane from the requirement text, arithmetic form
   function automatic int model_src(logic [15:0] p, int id);
      int g;
      int k;
      int r;
      k = int'(p[2:0]);
      if (p[15]) return (id / 4) * 4 + int'(p[2*(id%4) +: 2]);
      if (p[11:10] != 2'b00) return id;
      case (p[14:12])
         3'd0: begin
            r = 0;
            for (int b = 0; b < 5; b++) begin
               case (p[2*b +: 2])
                  2'b00: ;
                  2'b01: r += (1 << b);
                  2'b10: if (((id >> b) & 1) == 1) r += (1 << b);
                  default: if (((id >> b) & 1) == 0) r += (1 << b);
               endcase
            end
            return r;
         end
         3'd1: begin
            if (k < 1 || k > 5) return id;
            g = 1 << k;
            return (id / g) * g + (int'(p[8:4]) % g);
         end
         3'd2: begin
            if (k > 4) return id;
            g = 1 << k;
            return ((id / g) % 2 == 0) ? id + g : id - g;
         end
         3'd3: begin
            if (k < 1 || k > 5) return id;
            g = 1 << k;
            return (id / g) * g + (g - 1 - id % g);
         end
         default: return id;
      endcase
   endfunction

   task automatic load(int seed);
      for (int l = 0; l < LANES; l++) begin
         src_w[l] = {seed[15:0], 8'(l), 8'(l * 7 + 3)};
         data_i[l*DW +: DW] = src_w[l];
      end
   endtask

   task automatic check1(string req, logic [DW-1:0] act, logic [DW-1:0] exp, int lane);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s lane %0d actual=%h expected=%h", req, lane, act, exp);
      end
   endtask

   task automatic cmp_lanes(string req);
      for (int l = 0; l < LANES; l++) check1(req, data_o[l*DW +: DW], exp_q[l], l);
   endtask

   // drive one valid cycle at a negedge; check at the next negedge
   task automatic fire(string req, logic [15:0] p, logic [LANES-1:0] en, int seed);
      load(seed);
      pattern_i = p;
      lane_en_i = en;
      valid_i   = 1'b1;
      for (int l = 0; l < LANES; l++)
         if (en[l]) exp_q[l] = src_w[model_src(p, l)];
      @(negedge clk);
      valid_i = 1'b0;
      check1("R7", {31'd0, valid_o}, 32'd1, 0);
      cmp_lanes(req);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      valid_i = 1'b1;
      pattern_i = 16'h0;
      lane_en_i = '1;
      load(16'h55);
      repeat (3) @(negedge clk);
      for (int l = 0; l < LANES; l++) exp_q[l] = '0;
      check1("R9", {31'd0, valid_o}, 32'd0, 0);
      cmp_lanes("R9");
      valid_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_quad;
      fire("R1", 16'h801B, '1, 16'h101);
      fire("R1", 16'h80E4, '1, 16'h102);
      fire("R1", 16'h80AA, '1, 16'h103);
   endtask

   task automatic t_bitmask;
      fire("R2", 16'h0000, '1, 16'h201);
      fire("R2", 16'h02B6, '1, 16'h202);
      fire("R2", 16'h03FF, '1, 16'h203);
      fire("R2", 16'h02AA, '1, 16'h204);
   endtask

   task automatic t_bcast;
      fire("R3", 16'h1011, '1, 16'h301);
      fire("R3", 16'h1135, '1, 16'h302);
      fire("R3", 16'h11F3, '1, 16'h303);
   endtask

   task automatic t_swap;
      fire("R4", 16'h2000, '1, 16'h401);
      fire("R4", 16'h2004, '1, 16'h402);
      fire("R4", 16'h2002, '1, 16'h403);
   endtask

   task automatic t_reverse;
      fire("R5", 16'h3001, '1, 16'h501);
      fire("R5", 16'h3005, '1, 16'h502);
      fire("R5", 16'h3003, '1, 16'h503);
   endtask

   task automatic t_identity;
      fire("R6", 16'h5000, '1, 16'h601);
      fire("R6", 16'h1000, '1, 16'h602);
      fire("R6", 16'h2005, '1, 16'h603);
      fire("R6", 16'h3006, '1, 16'h604);
      fire("R6", 16'h0400, '1, 16'h605);
   endtask

   task automatic t_enable;
      fire("R8", 16'h3005, 32'hF0F0_1234, 16'h701);
      fire("R8", 16'h0000, 32'h0000_0000, 16'h702);
      load(16'h7FF);
      pattern_i = 16'h2000;
      lane_en_i = '1;
      valid_i   = 1'b0;
      @(negedge clk);
      check1("R7", {31'd0, valid_o}, 32'd0, 0);
      cmp_lanes("R8");
   endtask

   initial begin
      rst_n = 1'b0;
      valid_i = 1'b0;
      pattern_i = '0;
      lane_en_i = '0;
      data_i = '0;
      @(negedge clk);
      t_reset();
      t_quad();
      t_bitmask();
      t_bcast();
      t_swap();
      t_reverse();
      t_identity();
      t_enable();
      t_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule